// File: doc/BRIEF.md
# Outbound Request Deadline Tracker

This block watches outbound requests that must be answered and raises an event for any request that goes unanswered too long. When a read or an acknowledged write is issued, the block stores a deadline in the table slot named by the request's tag. The deadline is the current value of a shared free-running tick counter plus a programmable interval. Each slot then compares its deadline against the live counter, so no slot needs a counter of its own. A response carrying a tag frees the matching slot. A slot whose deadline passes first is freed and reported as a timeout.

The block also keeps three progress counts for software to read. The first counts writes started on the local write interface. The second counts write packets handed onward. The third counts acknowledged writes that are still open. Packet building, retries and bus handshakes are handled elsewhere.

Top module: `req_timeout_tracker`

## Requirements
- R1: Request kinds are encoded on `iss_kind` as follows: 0 posted write, 1 acknowledged write, 2 read, 3 streaming write. An accepted issue of kind 1 or 2 occupies slot `iss_tag` with deadline `(tick + timeout_ivl) mod 2^TICK_W`. Kinds 0 and 3 occupy no slot.
- R2: An occupied slot expires when `(tick - deadline) mod 2^TICK_W` is below half the counter range. The cycle after it is picked, `to_pulse` is high for one cycle with `to_tag` set to its tag, and the slot is freed.
- R3: `timeout_ivl` must stay below half the counter range. Under that limit, expiry is correct across counter wraparound: a deadline past the wrap point does not fire early.
- R4: A response to an occupied slot frees that slot. If the response arrives in the same cycle the slot expires, the response wins and no timeout is reported.
- R5: A response whose tag names a free slot changes no state. It raises `unexp_pulse` for exactly one cycle, on the next cycle.
- R6: `iss_stall` is high combinationally, and the issue is not accepted, when a kind 1 or 2 issue names an occupied slot. This includes the case where all slots are full. Kinds 0 and 3 never stall.
- R7: When several slots are expired at once, one timeout is reported per cycle, lowest tag first.
- R8: `wr_start_cnt` increments once for each cycle in which `wr_start` is high.
- R9: `wr_pkt_cnt` increments once for each accepted issue of kind 0, 1 or 3. Reads and stalled issues do not count.
- R10: `pend_cnt` rises on each accepted kind 1 issue. It falls when a kind 1 slot is freed by a response or by a timeout. It never exceeds the slot count.
- R11: After reset, all slots are free and the pulses, counts and stall are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | TICK_W | Shared free-running counter value |
| timeout_ivl | input | TICK_W | Programmable response interval |
| wr_start | input | 1 | A write began on the local write interface |
| iss_valid | input | 1 | Outbound request issued this cycle |
| iss_tag | input | TAG_W | Tag of the issued request |
| iss_kind | input | 2 | Kind of the issued request (encoding in R1) |
| iss_stall | output | 1 | Issue refused because the slot is occupied |
| rsp_valid | input | 1 | Response received this cycle |
| rsp_tag | input | TAG_W | Tag carried by the response |
| to_pulse | output | 1 | Timeout event, one cycle |
| to_tag | output | TAG_W | Tag of the timed-out request |
| unexp_pulse | output | 1 | Response to a free slot, one cycle |
| wr_start_cnt | output | CNT_W | Local write starts seen |
| wr_pkt_cnt | output | CNT_W | Write packets forwarded |
| pend_cnt | output | $clog2(2**TAG_W+1) | Open acknowledged writes |

## Verification
The bench sets deadlines on both sides of the counter wrap. A plain magnitude compare would fire those slots at once, one tick before the wrap. It lands a response in the very cycle its deadline is reached, which catches a design that lets the timeout win or counts the write as closed twice. Two slots are made to expire at once by jumping the tick. If the design dropped one of them, or reported them out of order, a pulse would be missing or carry the wrong tag. It also fills every slot, then reissues to a busy tag and sends responses to free tags and to posted or streaming writes. A design that accepted those, or built slots for them, would show a wrong stall, pending count or unexpected-response pulse.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
   typedef enum logic [1:0] {
      RK_POSTED_WR = 2'd0,
      RK_ACKED_WR  = 2'd1,
      RK_READ      = 2'd2,
      RK_STREAM_WR = 2'd3
   } req_kind_e;

   function automatic logic wants_reply(input req_kind_e k);
      return (k == RK_ACKED_WR) || (k == RK_READ);
   endfunction

   function automatic logic is_write(input req_kind_e k);
      return k != RK_READ;
   endfunction
endpackage

// File: rtl/rtt_slot_table.sv
module rtt_slot_table #(
   parameter int TAG_W  = 3,
   parameter int TICK_W = 16,
   localparam int DEPTH = 1 << TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TICK_W-1:0] tick,
   input  logic [TICK_W-1:0] ivl,
   input  logic              alloc_en,
   input  logic [TAG_W-1:0]  alloc_tag,
   input  logic              alloc_ack,
   input  logic [DEPTH-1:0]  clr,
   output logic [DEPTH-1:0]  busy,
   output logic [DEPTH-1:0]  ack,
   output logic [DEPTH-1:0]  expired
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic              v_q;
      logic              a_q;
      logic [TICK_W-1:0] dl_q;
      logic [TICK_W-1:0] age;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q  <= 1'b0;
            a_q  <= 1'b0;
            dl_q <= '0;
         end else if (alloc_en && alloc_tag == TAG_W'(g)) begin
            v_q  <= 1'b1;
            a_q  <= alloc_ack;
            dl_q <= tick + ivl;
         end else if (clr[g]) begin
            v_q <= 1'b0;
         end
      end

      // modular distance past the deadline; top bit set means not yet due
      assign age        = tick - dl_q;
      assign busy[g]    = v_q;
      assign ack[g]     = a_q;
      assign expired[g] = v_q & ~age[TICK_W-1];
   end
endmodule

// File: rtl/rtt_first_pick.sv
module rtt_first_pick #(
   parameter int N  = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/rtt_progress_counters.sv
module rtt_progress_counters #(
   parameter int CNT_W  = 16,
   parameter int PEND_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic              wr_pkt,
   input  logic              pend_inc,
   input  logic [1:0]        pend_dec,
   output logic [CNT_W-1:0]  wr_start_cnt,
   output logic [CNT_W-1:0]  wr_pkt_cnt,
   output logic [PEND_W-1:0] pend_cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_start_cnt <= '0;
         wr_pkt_cnt   <= '0;
         pend_cnt     <= '0;
      end else begin
         if (wr_start) wr_start_cnt <= wr_start_cnt + 1'b1;
         if (wr_pkt)   wr_pkt_cnt   <= wr_pkt_cnt + 1'b1;
         pend_cnt <= pend_cnt + PEND_W'(pend_inc) - PEND_W'(pend_dec);
      end
   end
endmodule

// File: rtl/req_timeout_tracker.sv
module req_timeout_tracker #(
   parameter int TAG_W  = 3,
   parameter int TICK_W = 16,
   parameter int CNT_W  = 16,
   localparam int DEPTH  = 1 << TAG_W,
   localparam int PEND_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TICK_W-1:0] tick,
   input  logic [TICK_W-1:0] timeout_ivl,
   input  logic              wr_start,
   input  logic              iss_valid,
   input  logic [TAG_W-1:0]  iss_tag,
   input  logic [1:0]        iss_kind,
   output logic              iss_stall,
   input  logic              rsp_valid,
   input  logic [TAG_W-1:0]  rsp_tag,
   output logic              to_pulse,
   output logic [TAG_W-1:0]  to_tag,
   output logic              unexp_pulse,
   output logic [CNT_W-1:0]  wr_start_cnt,
   output logic [CNT_W-1:0]  wr_pkt_cnt,
   output logic [PEND_W-1:0] pend_cnt
);
   import rtt_pkg::*;

   if (TAG_W < 1 || TAG_W > 8) begin : g_bad_tag
      $error("TAG_W out of range");
   end
   if (TICK_W < 2) begin : g_bad_tick
      $error("TICK_W must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   req_kind_e        kind;
   logic [DEPTH-1:0] busy, ack, expired, exp_live, clr, rsp_oh, to_oh;
   logic             needs, accept_slot, rsp_hit, to_any, wr_pkt;
   logic [TAG_W-1:0] to_idx;
   logic [1:0]       pend_dec;

   assign kind        = req_kind_e'(iss_kind);
   assign needs       = iss_valid && wants_reply(kind);
   assign iss_stall   = needs && busy[iss_tag];
   assign accept_slot = needs && !busy[iss_tag];
   assign wr_pkt      = iss_valid && is_write(kind) && !iss_stall;
   assign rsp_hit     = rsp_valid && busy[rsp_tag];
   assign rsp_oh      = rsp_hit ? (DEPTH'(1) << rsp_tag) : '0;
   // a response in the same cycle masks that slot's expiry
   assign exp_live    = expired & ~rsp_oh;
   assign to_oh       = to_any ? (DEPTH'(1) << to_idx) : '0;
   assign clr         = rsp_oh | to_oh;
   assign pend_dec    = {1'b0, rsp_hit && ack[rsp_tag]} + {1'b0, to_any && ack[to_idx]};

   rtt_slot_table #(.TAG_W(TAG_W), .TICK_W(TICK_W)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .ivl       (timeout_ivl),
      .alloc_en  (accept_slot),
      .alloc_tag (iss_tag),
      .alloc_ack (kind == RK_ACKED_WR),
      .clr       (clr),
      .busy      (busy),
      .ack       (ack),
      .expired   (expired)
   );

   rtt_first_pick #(.N(DEPTH)) u_pick (
      .req (exp_live),
      .any (to_any),
      .idx (to_idx)
   );

   rtt_progress_counters #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_start     (wr_start),
      .wr_pkt       (wr_pkt),
      .pend_inc     (accept_slot && kind == RK_ACKED_WR),
      .pend_dec     (pend_dec),
      .wr_start_cnt (wr_start_cnt),
      .wr_pkt_cnt   (wr_pkt_cnt),
      .pend_cnt     (pend_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_pulse    <= 1'b0;
         to_tag      <= '0;
         unexp_pulse <= 1'b0;
      end else begin
         to_pulse    <= to_any;
         to_tag      <= to_any ? to_idx : to_tag;
         unexp_pulse <= rsp_valid && !busy[rsp_tag];
      end
   end
endmodule

// File: rtl/rtt_chk.sv
module rtt_chk #(
   parameter int TAG_W  = 3,
   parameter int TICK_W = 16,
   localparam int DEPTH  = 1 << TAG_W,
   localparam int PEND_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [TICK_W-1:0] timeout_ivl,
   input logic              iss_stall,
   input logic              rsp_valid,
   input logic [TAG_W-1:0]  rsp_tag,
   input logic              to_pulse,
   input logic [TAG_W-1:0]  to_tag,
   input logic              unexp_pulse,
   input logic [PEND_W-1:0] pend_cnt
);
   localparam logic [TICK_W-1:0] HALF = TICK_W'(1) << (TICK_W - 1);

   // R3
   ivl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_ivl < HALF);

   // R4
   rsp_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      to_pulse |-> !($past(rsp_valid) && $past(rsp_tag) == to_tag));

   // R5
   unexp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unexp_pulse |-> $past(rsp_valid));

   // R10
   pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_cnt <= PEND_W'(DEPTH));

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_stall |=> pend_cnt <= $past(pend_cnt));
endmodule

bind req_timeout_tracker rtt_chk #(.TAG_W(TAG_W), .TICK_W(TICK_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .timeout_ivl (timeout_ivl),
   .iss_stall   (iss_stall),
   .rsp_valid   (rsp_valid),
   .rsp_tag     (rsp_tag),
   .to_pulse    (to_pulse),
   .to_tag      (to_tag),
   .unexp_pulse (unexp_pulse),
   .pend_cnt    (pend_cnt)
);

// File: tb/tb_req_timeout_tracker.sv
module tb_req_timeout_tracker;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] tick = '0;
   logic [15:0] timeout_ivl = 16'd4;
   logic        wr_start = 1'b0;
   logic        iss_valid = 1'b0;
   logic [2:0]  iss_tag = '0;
   logic [1:0]  iss_kind = '0;
   logic        iss_stall;
   logic        rsp_valid = 1'b0;
   logic [2:0]  rsp_tag = '0;
   logic        to_pulse;
   logic [2:0]  to_tag;
   logic        unexp_pulse;
   logic [15:0] wr_start_cnt, wr_pkt_cnt;
   logic [3:0]  pend_cnt;

   int n_chk = 0;
   int n_bad = 0;
   logic stall_seen;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   req_timeout_tracker dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .timeout_ivl(timeout_ivl),
      .wr_start(wr_start), .iss_valid(iss_valid), .iss_tag(iss_tag),
      .iss_kind(iss_kind), .iss_stall(iss_stall), .rsp_valid(rsp_valid),
      .rsp_tag(rsp_tag), .to_pulse(to_pulse), .to_tag(to_tag),
      .unexp_pulse(unexp_pulse), .wr_start_cnt(wr_start_cnt),
      .wr_pkt_cnt(wr_pkt_cnt), .pend_cnt(pend_cnt)
   );

   // tick | iss_v tag kind | rsp_v tag | exp: stall pulse ttag unexp pend
   localparam logic [27:0] VEC [NV] = '{
      {8'd0,  1'b1, 3'd1, 2'd1, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd1},
      {8'd1,  1'b1, 3'd2, 2'd2, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd1},
      {8'd2,  1'b1, 3'd1, 2'd1, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0, 4'd1},
      {8'd3,  1'b0, 3'd0, 2'd0, 1'b1, 3'd2, 1'b0, 1'b0, 3'd0, 1'b0, 4'd1},
      {8'd4,  1'b0, 3'd0, 2'd0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd1, 1'b0, 4'd0},
      {8'd5,  1'b0, 3'd0, 2'd0, 1'b1, 3'd1, 1'b0, 1'b0, 3'd0, 1'b1, 4'd0},
      {8'd6,  1'b1, 3'd3, 2'd0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd0},
      {8'd7,  1'b0, 3'd0, 2'd0, 1'b1, 3'd3, 1'b0, 1'b0, 3'd0, 1'b1, 4'd0},
      {8'd8,  1'b1, 3'd4, 2'd1, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd1},
      {8'd12, 1'b0, 3'd0, 2'd0, 1'b1, 3'd4, 1'b0, 1'b0, 3'd0, 1'b0, 4'd0},
      {8'd20, 1'b1, 3'd5, 2'd1, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd1},
      {8'd24, 1'b0, 3'd0, 2'd0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd5, 1'b0, 4'd0},
      {8'd25, 1'b1, 3'd5, 2'd2, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd0},
      {8'd26, 1'b1, 3'd5, 2'd1, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0, 4'd0}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic apply(input logic [15:0] tk, input logic iv, input logic [2:0] tg,
                        input logic [1:0] kd, input logic rv, input logic [2:0] rt,
                        input logic ws);
      tick = tk; iss_valid = iv; iss_tag = tg; iss_kind = kd;
      rsp_valid = rv; rsp_tag = rt; wr_start = ws;
      #1 stall_seen = iss_stall;
      @(posedge clk);
      @(negedge clk);
      iss_valid = 1'b0; rsp_valid = 1'b0; wr_start = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      iss_valid = 1'b0; rsp_valid = 1'b0; wr_start = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R11 reset state
      do_reset();
      #1;
      chk("R11 to_pulse", to_pulse, 0);
      chk("R11 unexp", unexp_pulse, 0);
      chk("R11 pend", pend_cnt, 0);
      chk("R11 wr_start_cnt", wr_start_cnt, 0);
      chk("R11 wr_pkt_cnt", wr_pkt_cnt, 0);
      chk("R11 stall", iss_stall, 0);

      // table walk: R1 R2 R4 R5 R6 R10
      for (int v = 0; v < NV; v++) begin
         logic [27:0] e;
         e = VEC[v];
         apply({8'd0, e[27:20]}, e[19], e[18:16], e[15:14], e[13], e[12:10], 1'b0);
         chk($sformatf("R6 stall v%0d", v), stall_seen, e[9]);
         chk($sformatf("R2 pulse v%0d", v), to_pulse, e[8]);
         if (e[8]) chk($sformatf("R2 tag v%0d", v), to_tag, e[7:5]);
         chk($sformatf("R5 unexp v%0d", v), unexp_pulse, e[4]);
         chk($sformatf("R10 pend v%0d", v), pend_cnt, e[3:0]);
      end
      chk("R9 packets after table", wr_pkt_cnt, 4);

      // R8 R9 counters, R1 stream write makes no slot
      do_reset();
      apply(16'd0, 0, 0, 0, 0, 0, 1);
      apply(16'd1, 0, 0, 0, 0, 0, 1);
      apply(16'd2, 0, 0, 0, 0, 0, 1);
      chk("R8 wr_start_cnt", wr_start_cnt, 3);
      apply(16'd3, 1, 3'd1, 2'd3, 0, 0, 0);
      apply(16'd4, 1, 3'd2, 2'd0, 0, 0, 0);
      apply(16'd5, 1, 3'd3, 2'd2, 0, 0, 0);
      chk("R9 wr_pkt_cnt", wr_pkt_cnt, 2);
      chk("R10 pend no ack", pend_cnt, 0);
      apply(16'd6, 0, 0, 0, 1, 3'd1, 0);
      chk("R1 stream no slot", unexp_pulse, 1);

      // R3 wraparound
      do_reset();
      apply(16'hFFFE, 1, 3'd0, 2'd2, 0, 0, 0);
      apply(16'hFFFF, 0, 0, 0, 0, 0, 0);
      chk("R3 no early fire", to_pulse, 0);
      apply(16'h0001, 0, 0, 0, 0, 0, 0);
      chk("R3 not yet", to_pulse, 0);
      apply(16'h0002, 0, 0, 0, 0, 0, 0);
      chk("R3 fire after wrap", to_pulse, 1);
      chk("R3 tag", to_tag, 0);

      // R7 simultaneous expiry
      do_reset();
      apply(16'd100, 1, 3'd7, 2'd1, 0, 0, 0);
      apply(16'd101, 1, 3'd6, 2'd1, 0, 0, 0);
      chk("R10 two open", pend_cnt, 2);
      apply(16'd110, 0, 0, 0, 0, 0, 0);
      chk("R7 first pulse", to_pulse, 1);
      chk("R7 lowest tag", to_tag, 6);
      chk("R10 after first", pend_cnt, 1);
      apply(16'd111, 0, 0, 0, 0, 0, 0);
      chk("R7 second pulse", to_pulse, 1);
      chk("R7 next tag", to_tag, 7);
      apply(16'd112, 0, 0, 0, 0, 0, 0);
      chk("R2 single cycle", to_pulse, 0);
      chk("R10 drained", pend_cnt, 0);

      // R6 full table
      do_reset();
      for (int t = 0; t < 8; t++) apply(16'd200, 1, 3'(t), 2'd2, 0, 0, 0);
      apply(16'd200, 1, 3'd3, 2'd1, 0, 0, 0);
      chk("R6 full stall", stall_seen, 1);
      chk("R6 full pend", pend_cnt, 0);
      apply(16'd200, 1, 3'd3, 2'd0, 0, 0, 0);
      chk("R6 posted no stall", stall_seen, 0);
      chk("R9 posted counted", wr_pkt_cnt, 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule